// File: doc/BRIEF.md
# Latching Interrupt Priority Arbiter

This block sits between a set of hardware interrupt request lines and the CPU's exception sequencer. Each request line sets a sticky pending bit. The bit stays set after the line drops, so a short request pulse is not lost. The CPU's I bit masks all hardware sources. A software-interrupt request is a separate synchronous input. It does not pass through the pending bits and the I bit does not mask it.

When the sequencer pulses its interrupt-start strobe, the block arbitrates once and freezes the result as a vector index. The software request wins over any hardware bit. Among unmasked hardware bits, the lowest-numbered line wins. The frozen index stays constant while the sequencer fetches the vector. Requests that arrive later, whatever their priority, cannot replace it.

The selection is released in two ways. The sequencer's serviced acknowledge releases it and clears only the chosen source's pending bit. Clearing the I bit also releases it, but leaves every pending bit intact.

Top module: `irq_latch_arb`

## Requirements
- R1: A request line that is high at a rising clock edge sets its pending bit at that edge. The bit stays set after the line returns low.
- R2: `int_pend_o` is high exactly when three conditions hold: at least one pending bit is set, `i_mask_i` is 0, and no selection is frozen.
- R3: With `i_mask_i` at 1 and `swi_req_i` at 0, a start strobe freezes no selection, even if hardware bits are pending.
- R4: A start strobe with hardware bits pending and the mask clear selects the lowest-numbered pending line. Line k gives index k.
- R5: A start strobe with `swi_req_i` high selects index N_IRQ, whatever the hardware bits and the I bit are.
- R6: While a selection is frozen, further start strobes and new requests of any priority leave `vec_idx_o` and `vec_valid_o` unchanged.
- R7: A serviced acknowledge while frozen has two effects. It releases the selection. It also clears the pending bit of the selected hardware line, and only that bit. An acknowledge of a software selection clears no hardware bit.
- R8: The I bit falling while frozen releases the selection and clears no pending bit. A fall means 1 at the previous edge and 0 at the current edge.
- R9: Reset clears all pending bits and any frozen selection.
- R10: `vec_valid_o` is 1 exactly while a selection is frozen. `vec_idx_o` reads 0 whenever `vec_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | N_IRQ | Hardware request lines, bit 0 highest priority |
| swi_req_i | input | 1 | Software-interrupt request, not maskable |
| i_mask_i | input | 1 | CPU I bit, masks hardware requests |
| int_start_i | input | 1 | Interrupt-processing start strobe |
| int_done_i | input | 1 | Serviced acknowledge |
| int_pend_o | output | 1 | Unmasked request waiting, no selection frozen |
| vec_valid_o | output | 1 | Selection frozen |
| vec_idx_o | output | $clog2(N_IRQ+1) | Frozen vector index, N_IRQ for software |

## Verification
Every result is due one edge after its stimulus, because each path crosses exactly one register:
- a request pulse shows on `int_pend_o` after the edge that samples it;
- a start strobe shows on `vec_valid_o` and `vec_idx_o` after its edge;
- an acknowledge or an I-bit fall shows its release after its edge.

The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each check therefore observes the state one register stage after the stimulus. Checks that no bit was lost are made at the ports, by running a further start strobe and reading the index that comes back.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  function automatic int idx_width(input int n_irq);
    return $clog2(n_irq + 1);
  endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] pend_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
    // a line still high in the clear cycle stays pending
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= (pend_q[g] & ~clr_i[g]) | req_i[g];
    end

    // R1
    latch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[g] |=> pend_q[g]);
    // R7
    latch_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !req_i[g]) |=> !pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = idx_width(N_IRQ)
) (
  input  logic [N_IRQ-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest set index is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_sel_hold.sv
module irq_sel_hold
  import irq_arb_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = idx_width(N_IRQ),
  localparam logic [IDX_W-1:0] SWI_IDX = IDX_W'(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             mask_i,
  input  logic             swi_i,
  input  logic             hw_any_i,
  input  logic [IDX_W-1:0] hw_idx_i,
  output logic             frz_o,
  output logic [IDX_W-1:0] sel_o,
  output logic [N_IRQ-1:0] clr_o
);
  logic             frz_q, mask_q, mask_fell, rel, take;
  logic [IDX_W-1:0] sel_q;

  assign mask_fell = mask_q & ~mask_i;
  assign rel       = frz_q & (done_i | mask_fell);
  assign take      = start_i & ~frz_q & (swi_i | hw_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q  <= 1'b0;
      sel_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      mask_q <= mask_i;
      if (take) begin
        frz_q <= 1'b1;
        sel_q <= swi_i ? SWI_IDX : hw_idx_i;
      end else if (rel) begin
        frz_q <= 1'b0;
        sel_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_clr
    assign clr_o[g] = frz_q & done_i & (sel_q == IDX_W'(g));
  end

  assign frz_o = frz_q;
  assign sel_o = sel_q;

  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !done_i && !mask_fell) |=> (frz_q && $stable(sel_q)));
  // R5
  swi_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !frz_q && swi_i) |=> (frz_q && sel_q == SWI_IDX));
  // R7
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  // R8
  mask_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && mask_fell) |=> !frz_q);
endmodule

// File: rtl/irq_latch_arb.sv
module irq_latch_arb
  import irq_arb_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = idx_width(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             swi_req_i,
  input  logic             i_mask_i,
  input  logic             int_start_i,
  input  logic             int_done_i,
  output logic             int_pend_o,
  output logic             vec_valid_o,
  output logic [IDX_W-1:0] vec_idx_o
);
  logic [N_IRQ-1:0] pend, clr, unmasked;
  logic             hw_any, frz;
  logic [IDX_W-1:0] hw_idx, sel;

  irq_pend_latch #(.N_IRQ(N_IRQ)) u_latch (
    .clk_i, .rst_ni, .req_i(irq_req_i), .clr_i(clr), .pend_o(pend)
  );

  assign unmasked = i_mask_i ? '0 : pend;

  irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
    .req_i(unmasked), .any_o(hw_any), .idx_o(hw_idx)
  );

  irq_sel_hold #(.N_IRQ(N_IRQ)) u_hold (
    .clk_i, .rst_ni,
    .start_i(int_start_i), .done_i(int_done_i), .mask_i(i_mask_i),
    .swi_i(swi_req_i), .hw_any_i(hw_any), .hw_idx_i(hw_idx),
    .frz_o(frz), .sel_o(sel), .clr_o(clr)
  );

  assign int_pend_o  = hw_any & ~frz;
  assign vec_valid_o = frz;
  assign vec_idx_o   = sel;

  // R3
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_start_i && !vec_valid_o && !swi_req_i && i_mask_i) |=> !vec_valid_o);
  // R4
  prio_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_start_i && !vec_valid_o && !swi_req_i && int_pend_o) |=>
      (vec_valid_o && pend[vec_idx_o]));
  // R10
  idx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_idx_o == '0));
endmodule

// File: tb/irq_latch_arb_tb_top.sv
`timescale 1ns/1ps
module irq_latch_arb_tb_top;
  localparam int N = 8;
  localparam int W = $clog2(N + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         swi = 1'b0, imask = 1'b0, start = 1'b0, done = 1'b0;
  logic         pend_o, valid_o;
  logic [W-1:0] idx_o;
  int           n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_latch_arb #(.N_IRQ(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .swi_req_i(swi),
    .i_mask_i(imask), .int_start_i(start), .int_done_i(done),
    .int_pend_o(pend_o), .vec_valid_o(valid_o), .vec_idx_o(idx_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_line(input int k);
    req[k] = 1'b1; step(); req[k] = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic do_done();
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 pend", pend_o, 0);
    chk("R9 valid", valid_o, 0);
    chk("R10 idx", idx_o, 0);
  endtask

  task automatic t_prio_hold();
    req[5] = 1'b1; req[2] = 1'b1; step(); req = '0;
    step();
    chk("R1 pend after drop", pend_o, 1);
    do_start();
    chk("R4 valid", valid_o, 1);
    chk("R4 idx", idx_o, 2);
    chk("R2 pend low while frozen", pend_o, 0);
    pulse_line(0);
    do_start();
    chk("R6 idx held", idx_o, 2);
    chk("R6 valid held", valid_o, 1);
    do_done();
    chk("R7 released", valid_o, 0);
    chk("R10 idx zero", idx_o, 0);
    chk("R2 pend remaining", pend_o, 1);
    do_start();
    chk("R4 idx line0", idx_o, 0);
    do_done();
    do_start();
    chk("R7 other bit kept", idx_o, 5);
    do_done();
    chk("R7 all cleared", pend_o, 0);
  endtask

  task automatic t_mask();
    pulse_line(3);
    imask = 1'b1; step();
    chk("R2 masked pend", pend_o, 0);
    do_start();
    chk("R3 no freeze", valid_o, 0);
    imask = 1'b0; step();
    chk("R2 unmasked pend", pend_o, 1);
    do_start();
    chk("R4 idx line3", idx_o, 3);
    do_done();
  endtask

  task automatic t_swi();
    pulse_line(1);
    imask = 1'b1; swi = 1'b1;
    do_start();
    swi = 1'b0;
    chk("R5 valid", valid_o, 1);
    chk("R5 idx", idx_o, N);
    do_done();
    imask = 1'b0; step();
    chk("R7 swi ack keeps hw", pend_o, 1);
    do_start();
    chk("R4 idx line1", idx_o, 1);
    imask = 1'b1; step();
    chk("R6 held under mask", idx_o, 1);
    imask = 1'b0; step();
    chk("R8 released", valid_o, 0);
    chk("R8 bit kept", pend_o, 1);
    do_start();
    chk("R8 same line again", idx_o, 1);
    do_done();
    chk("R7 done", pend_o, 0);
  endtask

  task automatic t_reset_mid();
    pulse_line(4);
    pulse_line(6);
    do_start();
    chk("R4 idx line4", idx_o, 4);
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R9 valid cleared", valid_o, 0);
    chk("R9 pend cleared", pend_o, 0);
    chk("R9 idx cleared", idx_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_prio_hold();
    t_mask();
    t_swi();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule